// File: doc/BRIEF.md
# Greedy Overlap Flip-Sequence Encoder

This block generates the serial stream that steers a slice-mutation decoder. The decoder holds a K-bit shift register whose value names one bit of a 2^K-bit test slice. A flip strobe inverts the slice bit that the register currently addresses. The encoder is given the present slice and the wanted slice. It works out which bits differ, then produces the shortest greedy sequence of shifted bits and flip strobes that turns one slice into the other.

Each shifted bit enters the register at its most significant end. The encoder can therefore reuse the bits that are already in the register. The distance from state s to state t is the fewest shifted-in bits after which the register reads t, and it is 0 when s equals t. At every step the encoder picks the pending target that is closest to its current state, where ties go to the lowest index. It then shifts in exactly the bits that target needs and strobes the flip.

The encoder keeps its own copy of the register and does not reset it between slices. Each slice therefore starts from the state the previous slice left behind.

Top module: `greedy_flip_encoder`

## Requirements
- R1: After reset `dec_state` is 0, and `busy`, `done`, `flip_en` and `shift_valid` are all 0.
- R2: A `start` pulse while idle loads the pending set `slice_a ^ slice_b` and raises `busy` on the next cycle. A `start` pulse while busy has no effect on the flips performed.
- R3: In a cycle with `shift_valid` high, the register becomes `{ser_bit, dec_state[K-1:1]}`, so the new bit enters at the most significant end. In all other cycles the register holds its value.
- R4: The distance d(s,t) is the smallest d in 0..K for which the low K-d bits of t equal `s >> d`. Reaching a target costs exactly d shift cycles followed by one flip cycle.
- R5: The next target is the pending index with the smallest distance from the current state, and ties go to the lowest index. Example with K=3: from state 4 with bits 2 and 6 pending, the flips happen at 2 and then 6, using 3 shift cycles.
- R6: For a target t at distance d, the bits t[K-d], t[K-d+1], ..., t[K-1] are emitted on `ser_bit` in that order, one per cycle. Example: from state 0 to target 3, the stream is 1, 1, 0.
- R7: `flip_en` is high for exactly one cycle while `dec_state` equals the target, never in the same cycle as `shift_valid`. This includes an immediate flip, with no shift, when the current state is itself pending.
- R8: `done` pulses for one cycle once the pending set is empty, and the encoder is idle on the next cycle. The number of `busy` cycles is the sum over targets of (d+1), plus 1. An empty set therefore gives 1 cycle.
- R9: The register value at the end of a slice is the starting state for the next slice.
- R10: A decoder driven by the stream, starting from `slice_a`, ends holding `slice_b`.
- R11: Over all ordered pairs of distinct single-flip start and target states, the total number of shift cycles equals the sum of d(s,t).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin encoding one slice pair (used only while idle) |
| slice_a | input | 2^K | Present slice value |
| slice_b | input | 2^K | Wanted slice value |
| ser_bit | output | 1 | Serial bit to shift into the decoder register |
| shift_valid | output | 1 | Decoder register shifts `ser_bit` in this cycle |
| flip_en | output | 1 | Decoder inverts the slice bit addressed by its register |
| busy | output | 1 | Encoding in progress |
| done | output | 1 | One-cycle pulse: all flips issued |
| dec_state | output | K | Encoder's copy of the decoder register |

## Verification
A single target reached from the reset state shows the order in which the bits are emitted, because a reversed stream would land on a different state. The two-flip case from state 4 separates greedy order from ascending order by its flip sequence and its cycle count. A target equal to the current state, and a slice pair with no difference, exercise the zero-distance flip and the immediate `done`. Multi-bit random and full-inversion slice pairs, a `start` pulse injected mid-run, and a sweep over every distinct pair of start and target states compare the rebuilt slice, the flip order, the cycle count and the final state with an independent greedy model.

// File: rtl/gfe_pkg.sv
package gfe_pkg;
   typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} gfe_phase_e;
endpackage

// File: rtl/gfe_dist_unit.sv
// Overlap distance from the current register state to every candidate index.
module gfe_dist_unit #(
   parameter int K = 3,
   localparam int N  = 1 << K,
   localparam int DW = $clog2(K + 1)
) (
   input  logic [K-1:0]    state_i,
   output logic [N*DW-1:0] dist_o
);
   for (genvar c = 0; c < N; c++) begin : g_cand
      localparam logic [K-1:0] CAND = K'(c);
      always_comb begin
         logic [DW-1:0] d_v;
         logic [K-1:0]  msk;
         d_v = DW'(K);
         msk = '0;
         for (int d = K - 1; d >= 0; d--) begin
            msk = K'((1 << (K - d)) - 1);
            if (((CAND ^ (state_i >> d)) & msk) == '0) d_v = DW'(d);
         end
         dist_o[c*DW +: DW] = d_v;
      end
   end
endmodule

// File: rtl/gfe_pick.sv
// Nearest pending candidate; ties resolve to the lowest index.
module gfe_pick #(
   parameter int K = 3,
   localparam int N  = 1 << K,
   localparam int DW = $clog2(K + 1)
) (
   input  logic [N-1:0]    pend_i,
   input  logic [N*DW-1:0] dist_i,
   output logic            any_o,
   output logic [K-1:0]    idx_o,
   output logic [DW-1:0]   dist_o
);
   always_comb begin
      any_o  = 1'b0;
      idx_o  = '0;
      dist_o = DW'(K);
      for (int i = 0; i < N; i++) begin
         if (pend_i[i] && (!any_o || (dist_i[i*DW +: DW] < dist_o))) begin
            any_o  = 1'b1;
            idx_o  = K'(i);
            dist_o = dist_i[i*DW +: DW];
         end
      end
   end
endmodule

// File: rtl/greedy_flip_encoder.sv
module greedy_flip_encoder #(
   parameter int K = 3,
   localparam int N  = 1 << K,
   localparam int DW = $clog2(K + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] slice_a,
   input  logic [N-1:0] slice_b,
   output logic         ser_bit,
   output logic         shift_valid,
   output logic         flip_en,
   output logic         busy,
   output logic         done,
   output logic [K-1:0] dec_state
);
   import gfe_pkg::*;

   if (K < 1 || K > 10) begin : g_bad_k
      $error("greedy_flip_encoder: K must lie in 1..10");
   end

   gfe_phase_e     phase_q;
   logic [N-1:0]   pend_q;
   logic [K-1:0]   state_q;
   logic [K-1:0]   tgt_q;
   logic [DW-1:0]  rem_q;
   logic           lock_q;

   logic [N*DW-1:0] dist_all;
   logic            pick_any;
   logic [K-1:0]    pick_idx;
   logic [DW-1:0]   pick_dist;

   gfe_dist_unit #(.K(K)) dist_i (
      .state_i (state_q),
      .dist_o  (dist_all)
   );

   gfe_pick #(.K(K)) pick_i (
      .pend_i  (pend_q),
      .dist_i  (dist_all),
      .any_o   (pick_any),
      .idx_o   (pick_idx),
      .dist_o  (pick_dist)
   );

   // A target, once chosen, stays locked until its flip is issued.
   logic [K-1:0]  cur_tgt;
   logic [DW-1:0] cur_rem;
   logic          running;
   logic          nxt_bit;

   always_comb begin
      cur_tgt = lock_q ? tgt_q : pick_idx;
      cur_rem = lock_q ? rem_q : pick_dist;
      running = (phase_q == PH_RUN);
      nxt_bit = 1'b0;
      for (int i = 0; i < K; i++) begin
         if (i == K - int'(cur_rem)) nxt_bit = cur_tgt[i];
      end
   end

   assign done        = running && !lock_q && !pick_any;
   assign flip_en     = running && !done && (cur_rem == '0);
   assign shift_valid = running && !done && (cur_rem != '0);
   assign ser_bit     = shift_valid ? nxt_bit : 1'b0;
   assign busy        = running;
   assign dec_state   = state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pend_q  <= '0;
         state_q <= '0;
         tgt_q   <= '0;
         rem_q   <= '0;
         lock_q  <= 1'b0;
      end else if (phase_q == PH_IDLE) begin
         if (start) begin
            pend_q  <= slice_a ^ slice_b;
            lock_q  <= 1'b0;
            phase_q <= PH_RUN;
         end
      end else if (done) begin
         phase_q <= PH_IDLE;
      end else if (flip_en) begin
         pend_q[cur_tgt] <= 1'b0;
         lock_q          <= 1'b0;
      end else begin
         state_q <= {nxt_bit, state_q[K-1:1]};
         tgt_q   <= cur_tgt;
         rem_q   <= cur_rem - DW'(1);
         lock_q  <= 1'b1;
      end
   end
endmodule

// File: rtl/gfe_chk.sv
module gfe_chk #(
   parameter int K = 3,
   localparam int N = 1 << K
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ser_bit,
   input logic         shift_valid,
   input logic         flip_en,
   input logic         busy,
   input logic         done,
   input logic [K-1:0] dec_state,
   input logic [N-1:0] pend
);
   // R3: shifted bit enters at the most significant end
   p_shift_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      shift_valid |=> dec_state == {$past(ser_bit), $past(dec_state[K-1:1])});

   // R3: register holds outside shift cycles
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_valid |=> $stable(dec_state));

   // R7: flip and shift never coincide
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(flip_en && shift_valid));

   // R7: a flip lands on a pending index and retires exactly one
   p_flip_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flip_en |-> pend[dec_state]);
   p_flip_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flip_en |=> $countones(pend) == $countones($past(pend)) - 1);

   // R8: done is quiet and is followed by idle
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !flip_en && !shift_valid && pend == '0);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R1: nothing issued while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !flip_en && !shift_valid && !done);
endmodule

bind greedy_flip_encoder gfe_chk #(.K(K)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .ser_bit     (ser_bit),
   .shift_valid (shift_valid),
   .flip_en     (flip_en),
   .busy        (busy),
   .done        (done),
   .dec_state   (dec_state),
   .pend        (pend_q)
);

// File: tb/greedy_flip_encoder_tb_top.sv
`timescale 1ns/1ps
module greedy_flip_encoder_tb_top;
   localparam int K = 3;
   localparam int N = 1 << K;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [N-1:0] slice_a = '0;
   logic [N-1:0] slice_b = '0;
   logic         ser_bit, shift_valid, flip_en, busy, done;
   logic [K-1:0] dec_state;

   always #4 clk = ~clk;  // 125 MHz

   greedy_flip_encoder #(.K(K)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .slice_a(slice_a), .slice_b(slice_b),
      .ser_bit(ser_bit), .shift_valid(shift_valid), .flip_en(flip_en),
      .busy(busy), .done(done), .dec_state(dec_state)
   );

   int checks = 0;
   int errors = 0;
   logic [K-1:0] exp_state = '0;
   int got_shifts;
   int got_bits [16];
   int finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reference distance: keep the top d bits of t above s shifted down by d.
   function automatic int ref_dist(input int s, input int t);
      for (int d = 0; d <= K; d++) begin
         int hi;
         hi = (d == 0) ? 0 : ((t >> (K - d)) << (K - d));
         if ((hi | (s >> d)) == t) return d;
      end
      return K;
   endfunction

   // Encode one slice pair; checks rebuilt slice, order, cycles, final state.
   task automatic run_slice(input logic [N-1:0] a, input logic [N-1:0] b,
                            input bit poke, input string tag);
      int ref_order [N];
      int got_order [N];
      int nref, ngot, exp_cyc, cyc, s;
      logic [N-1:0] mask, model;
      logic [K-1:0] mstate;
      bit order_ok;
      // reference greedy
      mask = a ^ b; s = int'(exp_state); nref = 0; exp_cyc = 1;
      while (mask != '0) begin
         int bi, bd;
         bi = -1; bd = K + 1;
         for (int i = 0; i < N; i++)
            if (mask[i] && ref_dist(s, i) < bd) begin bi = i; bd = ref_dist(s, i); end
         exp_cyc += bd + 1;
         ref_order[nref++] = bi;
         mask[bi] = 1'b0;
         s = bi;
      end
      // drive
      @(negedge clk);
      slice_a = a; slice_b = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2", {tag, " busy after start"}, int'(busy), 1);
      model = a; mstate = exp_state; ngot = 0; cyc = 0; got_shifts = 0;
      forever begin
         cyc++;
         if (shift_valid) begin
            if (got_shifts < 16) got_bits[got_shifts] = int'(ser_bit);
            got_shifts++;
            mstate = {ser_bit, mstate[K-1:1]};
         end
         if (flip_en) begin
            model[mstate] = ~model[mstate];
            if (ngot < N) got_order[ngot] = int'(mstate);
            ngot++;
         end
         if (done || cyc > 400) break;
         start = (poke && cyc == 2);
         if (poke && cyc == 2) begin slice_a = ~a; slice_b = a; end
         @(negedge clk);
         start = 1'b0;
      end
      chk(done === 1'b1, "R8", {tag, " done seen"}, int'(done), 1);
      chk(model == b, "R10", {tag, " rebuilt slice"}, int'(model), int'(b));
      chk(cyc == exp_cyc, "R8", {tag, " busy cycles"}, cyc, exp_cyc);
      order_ok = (ngot == nref);
      for (int i = 0; i < nref && i < ngot; i++)
         if (got_order[i] != ref_order[i]) order_ok = 1'b0;
      chk(order_ok, "R5", {tag, " flip order"}, ngot, nref);
      @(negedge clk);
      chk(busy === 1'b0, "R8", {tag, " idle after done"}, int'(busy), 0);
      exp_state = K'(s);
      chk(dec_state == exp_state, "R9", {tag, " retained state"},
          int'(dec_state), int'(exp_state));
      chk(dec_state == mstate, "R3", {tag, " register tracks stream"},
          int'(dec_state), int'(mstate));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(dec_state == '0 && !busy && !done && !flip_en && !shift_valid,
          "R1", "reset outputs", int'(dec_state), 0);
      rst_n = 1'b1;
      @(negedge clk);
      exp_state = '0;
   endtask

   task automatic t_bit_order();
      // state 0 -> target 3 (distance 3): stream must be 1,1,0
      run_slice(8'h08, 8'h00, 1'b0, "bitorder");
      chk(got_shifts == 3, "R4", "shifts to 3", got_shifts, 3);
      chk(got_bits[0] == 1 && got_bits[1] == 1 && got_bits[2] == 0, "R6",
          "stream t[0],t[1],t[2]", got_bits[0]*4 + got_bits[1]*2 + got_bits[2], 6);
   endtask

   task automatic t_greedy_example();
      run_slice(8'h10, 8'h00, 1'b0, "goto4");
      chk(dec_state == 3'd4, "R5", "at state 4", int'(dec_state), 4);
      // bits 2 and 6 from state 4: order 2 then 6, 3 shifts, 6 busy cycles
      run_slice(8'h44, 8'h00, 1'b0, "ex26");
      chk(got_shifts == 3, "R5", "shifts for 2,6", got_shifts, 3);
      chk(dec_state == 3'd6, "R5", "ends at 6", int'(dec_state), 6);
   endtask

   task automatic t_zero_dist();
      // state 6, flip bit 6: immediate flip
      run_slice(8'h40, 8'h00, 1'b0, "zero");
      chk(got_shifts == 0, "R7", "zero-distance shifts", got_shifts, 0);
   endtask

   task automatic t_empty();
      run_slice(8'h5A, 8'h5A, 1'b0, "empty");
      chk(got_shifts == 0, "R8", "empty mask shifts", got_shifts, 0);
   endtask

   task automatic t_patterns();
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      run_slice(8'h00, 8'hFF, 1'b0, "allflip");
      for (int n = 0; n < 6; n++) begin
         logic [N-1:0] a, b;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = lfsr[7:0];
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         b = lfsr[15:8];
         run_slice(a, b, 1'b0, $sformatf("rand%0d", n));
      end
   endtask

   task automatic t_busy_ignore();
      run_slice(8'h33, 8'hCC, 1'b1, "poke");
   endtask

   task automatic t_average();
      int sum_got, sum_ref;
      sum_got = 0; sum_ref = 0;
      for (int s = 0; s < N; s++)
         for (int t = 0; t < N; t++)
            if (s != t) begin
               if (int'(dec_state) != s) run_slice(N'(1) << s, '0, 1'b0, "seed");
               run_slice(N'(1) << t, '0, 1'b0, "pair");
               sum_got += got_shifts;
               sum_ref += ref_dist(s, t);
            end
      chk(sum_got == sum_ref, "R11", "total shifts over all pairs", sum_got, sum_ref);
      $display("mean shifts per single flip: %0d/%0d", sum_got, N*(N-1));
   endtask

   initial begin
      t_reset();
      t_bit_order();
      t_greedy_example();
      t_zero_dist();
      t_empty();
      t_patterns();
      t_busy_ignore();
      t_average();
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (finished == 0) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule